// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial EEPROM device driven over a three-wire link. The link has a select line, a shift clock and a data input, plus a data output that the model drives only when it has something to say. An organization input picks whether the storage is addressed as bytes or as 16-bit words. A host sends a framed command: a start bit, a two-bit opcode, an address field, and, for the writing commands, a data word. The model then reads or changes an internal register array.

All logic runs on a free-running system clock. The serial clock and select lines are sampled on that clock, and their edges are found by comparing each sample with the one before. The internal programming time is a count of system clocks. While that count runs, the device shows busy on its data output and refuses new commands. A write-enable latch must be set by a dedicated command before any programming command has an effect.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, every storage byte reads as 8'hFF, and the write-enable latch is clear, so programming is refused until an enable command arrives.
- R2: The output enable is low whenever the select line is low, and also while a command is being shifted in.
- R3: With select high, a command starts at the first rising serial clock that samples data-in at 1. Zeros before it are skipped. Next come two opcode bits and then the address, both MSB first. The address is 7 bits in byte mode (org low) and 6 bits in word mode (org high).
- R4: Opcode 2'b10 reads. On the rising edge that takes the last address bit, the output drives a single 0. Each following rising edge then drives the next data bit, MSB first (8 bits in byte mode, 16 in word mode). The edge after the last bit releases the output.
- R5: Word-mode word a is built from byte 2a as its upper half and byte 2a+1 as its lower half. These are the same bytes that byte mode addresses directly.
- R6: Opcode 2'b01 (write) takes a data word after the address and stores it at that address. No prior erase is needed.
- R7: Opcode 2'b11 (erase) sets the addressed word to all ones. Opcode 2'b00 with top address bits 2'b10 (erase-all) sets every byte to all ones. Opcode 2'b00 with top address bits 2'b01 (write-all) takes a data word and writes it to every location.
- R8: Opcode 2'b00 with top address bits 2'b11 sets the write-enable latch, and with 2'b00 clears it. The remaining address bits are don't-care but must still be clocked in.
- R9: Write, erase, erase-all and write-all leave the storage unchanged and start no busy period when the latch is clear.
- R10: A programming command takes effect on the falling edge of select, and only if its whole frame was received. A frame cut short has no effect.
- R11: After programming starts, raising select drives the output low while busy and high when ready. The busy period lasts BUSY_CLKS system clocks. A start bit accepted after ready releases the status.
- R12: Serial clock edges that arrive while busy are ignored. Nothing is decoded, and the status display continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Device select, active high |
| sclk_i | input | 1 | Serial shift clock, sampled on clk |
| sdi_i | input | 1 | Serial data in, taken on sclk rising |
| org_i | input | 1 | 1 = 16-bit words, 0 = bytes |
| sdo_o | output | 1 | Serial data out / ready-busy status |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |

## Verification
If the frame counter loses track of the field lengths, the dummy zero or the first data bit appears one serial clock early or late on the output, within the same read. If the write-enable latch or the pending-command state is wrong, it shows on the next read of the touched address, and also at once as a missing or extra busy status when select rises. If the busy timer is wrong, the status level or the acceptance of the following start bit goes wrong within a few system clocks of the programmed period's end.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DIN,
    ST_DOUT,
    ST_DONE
  } mw_state_t;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_ONE,
    WR_ALL
  } mw_wr_t;

  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_ERASE   = 2'b11;

  localparam logic [1:0] SPC_DISABLE  = 2'b00;
  localparam logic [1:0] SPC_WRALL    = 2'b01;
  localparam logic [1:0] SPC_ERALL    = 2'b10;
  localparam logic [1:0] SPC_ENABLE   = 2'b11;

  // address field length: one extra bit in byte mode
  function automatic int addr_bits(input logic org16, input int w16_aw);
    return org16 ? w16_aw : w16_aw + 1;
  endfunction

  function automatic int data_bits(input logic org16);
    return org16 ? 16 : 8;
  endfunction

endpackage

// File: rtl/mw_level_reg.sv
module mw_level_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] sig_q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) sig_q_o[g] <= 1'b0;
      else        sig_q_o[g] <= sig_i[g];
    end
  end
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start_i)      cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store
  import mw_pkg::*;
#(
  parameter int W16_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mw_wr_t              wr_op_i,
  input  logic [W16_AW:0]     wr_addr_i,
  input  logic                org16_i,
  input  logic [15:0]         wr_data_i,
  input  logic [W16_AW:0]     rd_addr_i,
  output logic [15:0]         rd_data_o
);
  localparam int BAW   = W16_AW + 1;
  localparam int DEPTH = 1 << BAW;

  logic [7:0] mem [DEPTH];

  function automatic logic hit(input int idx, input mw_wr_t op,
                               input logic [BAW-1:0] a, input logic org16);
    logic [BAW-1:0] ix;
    ix = BAW'(idx);
    if (op == WR_ALL) return 1'b1;
    if (org16)        return (ix >> 1) == a;
    return ix == a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_op_i != WR_NONE) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit(i, wr_op_i, wr_addr_i, org16_i))
          mem[i] <= (org16_i && (i % 2 == 0)) ? wr_data_i[15:8] : wr_data_i[7:0];
      end
    end
  end

  always_comb begin
    if (org16_i)
      rd_data_o = {mem[{rd_addr_i[BAW-2:0], 1'b0}], mem[{rd_addr_i[BAW-2:0], 1'b1}]};
    else
      rd_data_o = {8'h00, mem[rd_addr_i]};
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int W16_AW    = 6,
  parameter int BUSY_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic org_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int BAW = W16_AW + 1;

  mw_state_t      st;
  logic [4:0]     bitcnt;
  logic [1:0]     opc;
  logic [BAW-1:0] addr;
  logic [14:0]    dsh;
  logic [15:0]    rd_sh;
  logic           dout;
  logic           wen;
  mw_wr_t         pend_op;
  logic [BAW-1:0] pend_addr;
  logic [15:0]    pend_data;
  logic           stat_mode;

  // events brought out for the checker
  logic [1:0]     lvl_q;
  logic           sk_rise, cs_fall, wr_fire, busy, reading, st_idle;
  logic [BAW-1:0] addr_nxt;
  logic [1:0]     spc;
  logic [15:0]    rd_data;
  mw_wr_t         wr_op;

  mw_level_reg #(.N(2)) u_lvl (
    .clk(clk), .rst_n(rst_n), .sig_i({sel_i, sclk_i}), .sig_q_o(lvl_q)
  );

  assign sk_rise  = sclk_i & ~lvl_q[0];
  assign cs_fall  = ~sel_i & lvl_q[1];
  assign wr_fire  = cs_fall && wen && (pend_op != WR_NONE);
  assign wr_op    = wr_fire ? pend_op : WR_NONE;
  assign addr_nxt = {addr[BAW-2:0], sdi_i};
  assign spc      = org_i ? addr_nxt[W16_AW-1 -: 2] : addr_nxt[W16_AW -: 2];
  assign reading  = (st == ST_DOUT);
  assign st_idle  = (st == ST_IDLE);

  mw_busy_timer #(.CYCLES(BUSY_CLKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(wr_fire), .busy_o(busy)
  );

  mw_word_store #(.W16_AW(W16_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_op_i(wr_op), .wr_addr_i(pend_addr),
    .org16_i(org_i), .wr_data_i(pend_data), .rd_addr_i(addr_nxt),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      opc       <= '0;
      addr      <= '0;
      dsh       <= '0;
      rd_sh     <= '0;
      dout      <= 1'b0;
      wen       <= 1'b0;
      pend_op   <= WR_NONE;
      pend_addr <= '0;
      pend_data <= '0;
      stat_mode <= 1'b0;
    end else begin
      if (wr_fire) stat_mode <= 1'b1;
      if (!sel_i) begin
        st      <= ST_IDLE;
        pend_op <= WR_NONE;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (sdi_i && !busy) begin
            st        <= ST_OPC;
            bitcnt    <= 5'd1;
            stat_mode <= 1'b0;
          end
          ST_OPC: begin
            opc <= {opc[0], sdi_i};
            if (bitcnt == '0) begin
              st     <= ST_ADDR;
              bitcnt <= 5'(addr_bits(org_i, W16_AW) - 1);
              addr   <= '0;
            end else bitcnt <= bitcnt - 1'b1;
          end
          ST_ADDR: begin
            addr <= addr_nxt;
            if (bitcnt != '0) bitcnt <= bitcnt - 1'b1;
            else begin
              unique case (opc)
                OPC_READ: begin
                  st     <= ST_DOUT;
                  dout   <= 1'b0;
                  bitcnt <= 5'(data_bits(org_i));
                  rd_sh  <= org_i ? rd_data : {rd_data[7:0], 8'h00};
                end
                OPC_WRITE: begin
                  st     <= ST_DIN;
                  bitcnt <= 5'(data_bits(org_i) - 1);
                  dsh    <= '0;
                end
                OPC_ERASE: begin
                  st        <= ST_DONE;
                  pend_op   <= WR_ONE;
                  pend_addr <= addr_nxt;
                  pend_data <= '1;
                end
                default: begin
                  st <= ST_DONE;
                  unique case (spc)
                    SPC_ENABLE:  wen <= 1'b1;
                    SPC_DISABLE: wen <= 1'b0;
                    SPC_ERALL: begin
                      pend_op   <= WR_ALL;
                      pend_data <= '1;
                    end
                    default: begin
                      st     <= ST_DIN;
                      bitcnt <= 5'(data_bits(org_i) - 1);
                      dsh    <= '0;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DIN: begin
            dsh <= {dsh[13:0], sdi_i};
            if (bitcnt != '0) bitcnt <= bitcnt - 1'b1;
            else begin
              st        <= ST_DONE;
              pend_op   <= (opc == OPC_WRITE) ? WR_ONE : WR_ALL;
              pend_addr <= addr;
              pend_data <= {dsh, sdi_i};
            end
          end
          ST_DOUT: begin
            if (bitcnt != '0) begin
              dout   <= rd_sh[15];
              rd_sh  <= {rd_sh[14:0], 1'b0};
              bitcnt <= bitcnt - 1'b1;
            end else st <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_oe_o = sel_i & (reading | (stat_mode & st_idle));
  assign sdo_o    = sdo_oe_o & (reading ? dout : ~busy);

endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic busy,
  input logic wr_fire,
  input logic reading,
  input logic st_idle
);
  a_r2_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> !sdo_oe_o);

  a_r11_fire_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> busy);

  a_r10_fire_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !sel_i);

  a_r12_busy_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_idle) |=> st_idle);

  a_r11_status_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && !reading && busy) |-> !sdo_o);

  a_r4_read_ends_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !sel_i) |=> !reading);
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .busy(busy), .wr_fire(wr_fire), .reading(reading), .st_idle(st_idle)
);

// File: tb/mw_eeprom_slave_tb_top.sv
module mw_eeprom_slave_tb_top;
  localparam int W16_AW = 6;
  localparam int BUSY   = 400;
  localparam int DEPTH  = 128;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b0;
  logic sdo, sdo_oe;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.W16_AW(W16_AW), .BUSY_CLKS(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .org_i(org), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit     finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  logic [7:0]  ref_mem [DEPTH];
  bit          ref_wen = 0, ref_stat = 0;
  longint      t0 = -100000;
  int          pend_kind = 0;   // 0 none, 1 one word, 2 all
  int          pend_addr = 0;
  logic [15:0] pend_data = '0;
  bit          rd_drv = 0, rd_bit = 0, mon_on = 0;
  string       cur_req = "R2";
  int          pre_zeros = 0;

  function automatic int busy_state();  // 0 ready, 1 busy, 2 unsure
    if (cyc >= t0 && cyc < t0 + BUSY - 2) return 1;
    if (cyc >= t0 - 1 && cyc < t0 + BUSY + 2) return 2;
    return 0;
  endfunction

  function automatic int abits();
    return org ? W16_AW : W16_AW + 1;
  endfunction

  function automatic logic [15:0] ref_word(input int a);
    if (org) return {ref_mem[2*a], ref_mem[2*a+1]};
    return {8'h00, ref_mem[a]};
  endfunction

  // per-clock comparison of the output pins
  always @(posedge clk) begin : mon
    bit eoe, ok;
    int bs;
    #3;
    if (mon_on) begin
      eoe = rd_drv | (sel & ref_stat);
      bs  = busy_state();
      ok  = (sdo_oe === eoe);
      if (eoe && rd_drv) ok = ok && (sdo === rd_bit);
      else if (eoe && bs != 2) ok = ok && (sdo === (bs == 0));
      n_chk++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s cyc=%0d actual oe=%b do=%b expected oe=%b", cur_req, cyc, sdo_oe, sdo, eoe);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input bit b, input bit drv, input bit dbit, input bit clr, output bit smp);
    @(negedge clk) sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1; rd_drv = drv; rd_bit = dbit;
    if (clr) ref_stat = 0;
    @(negedge clk) smp = sdo;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk) sel = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) sel = 1'b0; rd_drv = 0;
    if (pend_kind != 0 && ref_wen) begin
      if (pend_kind == 2) begin
        for (int i = 0; i < DEPTH; i++)
          ref_mem[i] = (org && i % 2 == 0) ? pend_data[15:8] : pend_data[7:0];
      end else if (org) begin
        ref_mem[2*pend_addr] = pend_data[15:8];
        ref_mem[2*pend_addr+1] = pend_data[7:0];
      end else ref_mem[pend_addr] = pend_data[7:0];
      t0 = cyc + 1;
      ref_stat = 1;
    end
    pend_kind = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input int a);
    bit s;
    int n;
    n = abits();
    for (int i = 0; i < pre_zeros; i++) sk_bit(1'b0, 0, 0, 0, s);
    sk_bit(1'b1, 0, 0, 1, s);
    sk_bit(op[1], 0, 0, 0, s);
    sk_bit(op[0], 0, 0, 0, s);
    for (int i = n - 1; i >= 0; i--)
      sk_bit(a[i], (i == 0) && (op == 2'b10), 1'b0, 0, s);
  endtask

  task automatic do_read(input int a, input string req);
    bit s;
    logic [15:0] v, ew;
    int dw;
    cur_req = req;
    ew = ref_word(a);
    dw = org ? 16 : 8;
    v = '0;
    cs_up();
    send_hdr(2'b10, a);
    for (int i = dw - 1; i >= 0; i--) begin
      sk_bit(1'b0, 1, ew[i], 0, s);
      v = {v[14:0], s};
    end
    sk_bit(1'b0, 0, 0, 0, s);
    cs_down();
    chk(req, v, ew);
  endtask

  task automatic shift_data(input logic [15:0] d);
    bit s;
    for (int i = (org ? 15 : 7); i >= 0; i--) sk_bit(d[i], 0, 0, 0, s);
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input bit all);
    cs_up();
    send_hdr(all ? 2'b00 : 2'b01, all ? (1 << (abits() - 2)) : a);
    shift_data(d);
    pend_kind = all ? 2 : 1; pend_addr = a; pend_data = d;
    cs_down();
  endtask

  task automatic do_special(input logic [1:0] code);
    cs_up();
    send_hdr(2'b00, int'(code) << (abits() - 2));
    if (code == 2'b11) ref_wen = 1;
    if (code == 2'b00) ref_wen = 0;
    if (code == 2'b10) begin pend_kind = 2; pend_data = 16'hFFFF; end
    cs_down();
  endtask

  task automatic do_erase(input int a);
    cs_up();
    send_hdr(2'b11, a);
    pend_kind = 1; pend_addr = a; pend_data = 16'hFFFF;
    cs_down();
  endtask

  task automatic wait_ready();
    repeat (BUSY + 10) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R1", {15'd0, sdo_oe}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R1: erased contents, byte mode
    org = 1'b0;
    do_read(5, "R1");

    // R9 / R1: programming refused before enable
    cur_req = "R9";
    do_write(5, 16'h003C, 0);
    cs_up();
    chk("R9", {15'd0, sdo_oe}, 16'd0);
    cs_down();
    do_read(5, "R9");

    // R8 enable, R6 write, R11 status
    cur_req = "R8";
    do_special(2'b11);
    cur_req = "R11";
    do_write(5, 16'h00A5, 0);
    cs_up();
    repeat (3) @(negedge clk);
    chk("R11", {14'd0, sdo_oe, sdo}, 16'b10);
    wait_ready();
    chk("R11", {14'd0, sdo_oe, sdo}, 16'b11);
    cs_down();
    do_read(5, "R6");

    // R3: top address, leading zeros before start bit
    do_write(127, 16'h005A, 0);
    wait_ready();
    pre_zeros = 3;
    do_read(127, "R3");
    pre_zeros = 0;
    do_read(0, "R3");

    // R12: command during busy is ignored
    do_write(10, 16'h0011, 0);
    cur_req = "R12";
    cs_up();
    begin
      bit s;
      sk_bit(1'b1, 0, 0, 0, s);
      sk_bit(1'b0, 0, 0, 0, s);
      sk_bit(1'b1, 0, 0, 0, s);
      for (int i = 6; i >= 0; i--) sk_bit(10 >> i, 0, 0, 0, s);
      for (int i = 7; i >= 0; i--) sk_bit(8'h22 >> i, 0, 0, 0, s);
      chk("R12", {15'd0, sdo_oe}, 16'd1);
    end
    cs_down();
    wait_ready();
    do_read(10, "R12");

    // R10: truncated frame has no effect
    cur_req = "R10";
    cs_up();
    send_hdr(2'b01, 10);
    begin
      bit s;
      for (int i = 0; i < 4; i++) sk_bit(1'b0, 0, 0, 0, s);
    end
    cs_down();
    cs_up();
    chk("R10", {15'd0, sdo_oe}, 16'd0);
    cs_down();
    do_read(10, "R10");

    // R5 / R6: word mode and byte aliasing
    org = 1'b1;
    do_write(3, 16'hBEEF, 0);
    wait_ready();
    do_read(3, "R6");
    org = 1'b0;
    do_read(6, "R5");
    do_read(7, "R5");

    // R7: erase in word mode
    org = 1'b1;
    do_erase(3);
    wait_ready();
    do_read(3, "R7");

    // R7: write-all then erase-all in byte mode
    org = 1'b0;
    do_write(0, 16'h0077, 1);
    wait_ready();
    do_read(0, "R7");
    do_read(64, "R7");
    do_read(127, "R7");
    do_special(2'b10);
    wait_ready();
    do_read(9, "R7");

    // R8 disable then R9 ignored write
    cur_req = "R8";
    do_special(2'b00);
    do_write(4, 16'h0012, 0);
    do_read(4, "R8");

    repeat (5) @(negedge clk);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end
endmodule